// File: doc/BRIEF.md
# Timer Output Compare Unit

The block is a single 16-bit output-compare channel attached to a free-running 16-bit counter. Software on an 8-bit bus loads the compare value one byte at a time, and sets the pin level to drive and an interrupt enable in a control register. A built-in prescaler opens a compare window on every fourth clock. In that cycle the counter is tested against the stored value, and then it advances. On a match the block raises a status flag, copies the chosen level onto its compare pin and, if enabled, requests an interrupt.

A write to the high compare byte holds off all matching until the low byte is written. The 16-bit value is therefore never compared while only half of it is new. Software clears the flag in two steps: it reads the status register while the flag is set, then accesses the low compare byte. The compare bytes hold no reset value. They keep whatever was last written, across a reset as well.

Register map on `bus_addr`: 0 = status (bit 7 is the flag, writes have no effect), 1 = control (bit 0 = pin level, bit 1 = interrupt enable), 2 = compare high byte, 3 = compare low byte.

Top module: `ocu_top`

## Requirements
- R1: The compare high byte (address 2) and the compare low byte (address 3) can each be written without changing the other, and both read back the last value written.
- R2: Reset does not change the two compare bytes.
- R3: The counter on `cnt_o` starts at 0 after reset, advances by one every 4 clocks and wraps from 0xFFFF to 0x0000.
- R4: A match is tested only in the strobe cycle that ends a count period, against the count held during that period. On a match the flag (status bit 7) becomes 1 and `cmp_pin` takes the control level bit, both at the same edge at which the counter advances.
- R5: On every match the level bit is copied to `cmp_pin`, even when the flag is already set. Between matches the pin holds its value.
- R6: After a write to the high byte, no match is reported until the low byte has been written.
- R7: A write to the low byte alone does not suspend matching.
- R8: `irq` is 1 exactly while the flag is set and control bit 1 (interrupt enable) is set.
- R9: The flag is cleared by a read of the status register while the flag is set, followed by a read or write of the low compare byte. An access to the low byte with no such read before it leaves the flag set.
- R10: If a high-byte write falls in the same cycle as a strobe whose count equals the compare value, no match is reported and the pin does not change.
- R11: After reset the flag, the control register, `cmp_pin` and `irq` are 0, and matching is suspended until the low byte is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after `bus_rd` |
| cnt_o | output | 16 | Free-running counter value |
| cmp_pin | output | 1 | Compare output level |
| irq | output | 1 | Compare interrupt request |

## Verification
A high-byte write and a compare strobe can fall in the same cycle. In that case the inhibit has to win, even when the counter equals the stored value. The bench provokes this by loading a compare value a few counts ahead and waiting for the counter to reach it. It then times the high-byte write so that the write is sampled at the fourth edge after the counter changes, which is the edge that evaluates the match. The bench judges the result by checking, after the counter has moved past the value, that the pin kept its old level and that a status read returns a clear flag.

// File: rtl/ocu_pkg.sv
package ocu_pkg;
  typedef enum logic [1:0] {
    REG_STAT = 2'd0,
    REG_CTRL = 2'd1,
    REG_CMPH = 2'd2,
    REG_CMPL = 2'd3
  } ocu_reg_e;

  localparam int STAT_FLAG_BIT = 7;
  localparam int CTRL_LVL_BIT  = 0;
  localparam int CTRL_IE_BIT   = 1;
endpackage

// File: rtl/ocu_timebase.sv
module ocu_timebase #(
  parameter int PRESCALE = 4,
  parameter int CW       = 16
) (
  input  logic          clk,
  input  logic          rst,
  output logic          strobe_o,
  output logic [CW-1:0] cnt_o
);
  localparam int PHW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PHW-1:0] PH_LAST = PHW'(PRESCALE - 1);

  logic [PHW-1:0] phase_q;
  logic [CW-1:0]  cnt_q;

  assign strobe_o = (phase_q == PH_LAST);
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      cnt_q   <= '0;
    end else begin
      phase_q <= strobe_o ? '0 : phase_q + 1'b1;
      if (strobe_o) cnt_q <= cnt_q + 1'b1;
    end
  end

  // R3: counter steps by one after a strobe, holds otherwise
  p_cnt_step_r3: assert property (@(posedge clk) disable iff (rst)
    strobe_o |=> (cnt_q == CW'($past(cnt_q) + 1'b1)));
  p_cnt_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !strobe_o |=> $stable(cnt_q));
endmodule

// File: rtl/ocu_cmpregs.sv
module ocu_cmpregs #(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_hi,
  input  logic            wr_lo,
  input  logic            wr_ctrl,
  input  logic [DW-1:0]   wdata,
  output logic [2*DW-1:0] cmp_o,
  output logic            level_o,
  output logic            ie_o,
  output logic            inhibit_o
);
  import ocu_pkg::*;

  logic [DW-1:0] hi_q, lo_q;
  logic          level_q, ie_q, inhibit_q;

  // compare bytes carry no reset
  always_ff @(posedge clk) begin
    if (wr_hi) hi_q <= wdata;
    if (wr_lo) lo_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q   <= 1'b0;
      ie_q      <= 1'b0;
      inhibit_q <= 1'b1;
    end else begin
      if (wr_ctrl) begin
        level_q <= wdata[CTRL_LVL_BIT];
        ie_q    <= wdata[CTRL_IE_BIT];
      end
      if (wr_hi)      inhibit_q <= 1'b1;
      else if (wr_lo) inhibit_q <= 1'b0;
    end
  end

  assign cmp_o     = {hi_q, lo_q};
  assign level_o   = level_q;
  assign ie_o      = ie_q;
  assign inhibit_o = inhibit_q;

  // R6: high write suspends, low write releases
  p_hi_suspends_r6: assert property (@(posedge clk) disable iff (rst)
    wr_hi |=> inhibit_q);
  p_lo_releases_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_lo && !wr_hi) |=> !inhibit_q);
  p_inhibit_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!wr_lo && !wr_hi) |=> $stable(inhibit_q));
endmodule

// File: rtl/ocu_match.sv
module ocu_match #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          strobe,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] cmp,
  input  logic          inhibit,
  input  logic          hi_wr,
  input  logic          stat_rd,
  input  logic          lo_acc,
  input  logic          level,
  input  logic          ie,
  output logic          flag_o,
  output logic          pin_o,
  output logic          irq_o
);
  logic flag_q, arm_q, pin_q, hit;

  assign hit = strobe && !inhibit && !hi_wr && (cnt == cmp);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
      pin_q  <= 1'b0;
    end else begin
      if (hit) pin_q <= level;
      if (hit)                 flag_q <= 1'b1;
      else if (arm_q && lo_acc) flag_q <= 1'b0;
      if (lo_acc)                arm_q <= 1'b0;
      else if (stat_rd && flag_q) arm_q <= 1'b1;
    end
  end

  assign flag_o = flag_q;
  assign pin_o  = pin_q;
  assign irq_o  = flag_q && ie;

  // R4: flag and pin only move at a strobe edge
  p_flag_on_strobe_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(strobe));
  p_pin_on_strobe_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(pin_q) |-> ($past(strobe) || $past(rst)));
  // R9: flag falls only after a low-byte access
  p_clear_path_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(flag_q) |-> ($past(lo_acc) || $past(rst)));
  // R10: a high write blocks any match in its cycle
  p_hi_blocks_r10: assert property (@(posedge clk) disable iff (rst)
    hi_wr |=> !$rose(flag_q));
endmodule

// File: rtl/ocu_top.sv
module ocu_top #(
  parameter int DW       = 8,
  parameter int PRESCALE = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      bus_addr,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic [2*DW-1:0] cnt_o,
  output logic            cmp_pin,
  output logic            irq
);
  import ocu_pkg::*;
  localparam int CW = 2 * DW;

  logic          strobe, inhibit, level, ie, flag;
  logic [CW-1:0] cnt, cmp;
  logic          wr_hi, wr_lo, wr_ctrl, stat_rd, lo_acc;
  logic [DW-1:0] rdata_q;

  assign wr_hi   = bus_wr && (bus_addr == REG_CMPH);
  assign wr_lo   = bus_wr && (bus_addr == REG_CMPL);
  assign wr_ctrl = bus_wr && (bus_addr == REG_CTRL);
  assign stat_rd = bus_rd && (bus_addr == REG_STAT);
  assign lo_acc  = (bus_rd || bus_wr) && (bus_addr == REG_CMPL);

  ocu_timebase #(.PRESCALE(PRESCALE), .CW(CW)) u_tb (
    .clk(clk), .rst(rst), .strobe_o(strobe), .cnt_o(cnt)
  );

  ocu_cmpregs #(.DW(DW)) u_regs (
    .clk(clk), .rst(rst), .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_ctrl(wr_ctrl),
    .wdata(bus_wdata), .cmp_o(cmp), .level_o(level), .ie_o(ie),
    .inhibit_o(inhibit)
  );

  ocu_match #(.CW(CW)) u_match (
    .clk(clk), .rst(rst), .strobe(strobe), .cnt(cnt), .cmp(cmp),
    .inhibit(inhibit), .hi_wr(wr_hi), .stat_rd(stat_rd), .lo_acc(lo_acc),
    .level(level), .ie(ie), .flag_o(flag), .pin_o(cmp_pin), .irq_o(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      rdata_q <= '0;
      case (bus_addr)
        REG_STAT: rdata_q[STAT_FLAG_BIT] <= flag;
        REG_CTRL: begin
          rdata_q[CTRL_LVL_BIT] <= level;
          rdata_q[CTRL_IE_BIT]  <= ie;
        end
        REG_CMPH: rdata_q <= cmp[CW-1:DW];
        default:  rdata_q <= cmp[DW-1:0];
      endcase
    end
  end

  assign bus_rdata = rdata_q;
  assign cnt_o     = cnt;
endmodule

// File: tb/test_ocu_top.sv
module test_ocu_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst = 1'b1;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [15:0] cnt_o;
  logic        cmp_pin, irq;

  ocu_top i_ocu_top (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt_o(cnt_o), .cmp_pin(cmp_pin), .irq(irq)
  );

  int n_chk = 0, n_fail = 0;
  typedef struct { logic [7:0] val; string tag; } exp_t;
  exp_t exp_q[$];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, logic [7:0] e, string tag);
    exp_t it;
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    it.val = e; it.tag = tag;
    exp_q.push_back(it);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr_cmp(logic [15:0] v);
    wr(2'd2, v[15:8]);
    wr(2'd3, v[7:0]);
  endtask

  task automatic wait_cnt(logic [15:0] v);
    do @(negedge clk); while (cnt_o !== v);
  endtask

  // keep low byte away from a carry into the high byte
  task automatic pick();
    do @(negedge clk); while (cnt_o[7:0] < 8'd8 || cnt_o[7:0] > 8'hE0);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic clear_flag(logic [7:0] lo, string tag);
    rd(2'd0, 8'h80, tag);
    rd(2'd3, lo, tag);
    rd(2'd0, 8'h00, tag);
  endtask

  // monitor: pops the scoreboard when read data is due
  logic rd_d = 1'b0;
  always @(posedge clk) rd_d <= bus_rd;
  always @(negedge clk) begin
    if (rd_d) begin
      if (exp_q.size() == 0) chk("scoreboard underflow", 32'd1, 32'd0);
      else begin
        exp_t it;
        it = exp_q.pop_front();
        chk(it.tag, {24'd0, bus_rdata}, {24'd0, it.val});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] v, v2;
    int c;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    chk("R11 pin", cmp_pin, 0);
    chk("R11 irq", irq, 0);
    chk("R3 start", cnt_o, 0);
    rd(2'd0, 8'h00, "R11 status");
    rd(2'd1, 8'h00, "R11 ctrl");

    // R3 period
    wait_cnt(16'd2);
    v = cnt_o; c = 0;
    do begin @(negedge clk); c++; end while (cnt_o == v);
    chk("R3 period", c, 4);
    chk("R3 step", cnt_o, v + 16'd1);

    // R1 byte independence
    wr(2'd2, 8'hA5); wr(2'd3, 8'h3C);
    rd(2'd2, 8'hA5, "R1 hi"); rd(2'd3, 8'h3C, "R1 lo");
    wr(2'd2, 8'h5A);
    rd(2'd3, 8'h3C, "R1 lo kept"); rd(2'd2, 8'h5A, "R1 hi new");

    // R2 retention across reset, R11 inhibit after reset
    wr_cmp(16'h0010);
    do_reset();
    rd(2'd2, 8'h00, "R2 hi"); rd(2'd3, 8'h10, "R2 lo");
    wait_cnt(16'h0012);
    chk("R11 no match pin", cmp_pin, 0);
    rd(2'd0, 8'h00, "R11 no match flag");

    // R4 / R8 basic match, ie off then on
    wr(2'd1, 8'h01);
    v = cnt_o + 16'd3; wr_cmp(v);
    wait_cnt(v + 16'd1);
    chk("R4 pin", cmp_pin, 1);
    chk("R8 irq off", irq, 0);
    rd(2'd0, 8'h80, "R4 flag");
    wr(2'd1, 8'h03);
    @(negedge clk);
    chk("R8 irq on", irq, 1);

    // R5 level copied while flag already set
    wr(2'd1, 8'h02);
    v = cnt_o + 16'd3; wr_cmp(v);
    wait_cnt(v + 16'd1);
    chk("R5 pin", cmp_pin, 0);
    chk("R8 irq held", irq, 1);

    // R9 clear sequence
    rd(2'd3, v[7:0], "R9 lo unarmed");
    rd(2'd0, 8'h80, "R9 still set");
    rd(2'd3, v[7:0], "R9 lo armed");
    rd(2'd0, 8'h00, "R9 cleared");
    chk("R8 irq cleared", irq, 0);

    // R6 high write suspends until low write
    wr(2'd1, 8'h03);
    pick();
    v = cnt_o + 16'd4; wr_cmp(v);
    wr(2'd2, v[15:8]);
    wait_cnt(v + 16'd2);
    chk("R6 suspended pin", cmp_pin, 0);
    rd(2'd0, 8'h00, "R6 suspended flag");
    v2 = cnt_o + 16'd3;
    wr(2'd3, v2[7:0]);
    wait_cnt(v2 + 16'd1);
    chk("R6 released pin", cmp_pin, 1);
    clear_flag(v2[7:0], "R6 released flag");

    // R7 low-only write keeps matching
    wr(2'd1, 8'h02);
    pick();
    wr_cmp({cnt_o[15:8], 8'h00});
    v = cnt_o + 16'd3;
    wr(2'd3, v[7:0]);
    wait_cnt(v + 16'd1);
    chk("R7 pin", cmp_pin, 0);
    clear_flag(v[7:0], "R7 flag");

    // R10 high write on the matching strobe
    wr(2'd1, 8'h03);
    pick();
    v = cnt_o + 16'd3; wr_cmp(v);
    wait_cnt(v);
    repeat (2) @(negedge clk);
    wr(2'd2, v[15:8]);
    wait_cnt(v + 16'd2);
    chk("R10 pin", cmp_pin, 0);
    rd(2'd0, 8'h00, "R10 flag");

    repeat (4) @(negedge clk);
    chk("scoreboard drained", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule